// File: doc/BRIEF.md
# Event Latency Statistics Unit

This unit times events that are framed by a start pulse and a stop pulse. It tracks one event at a time. For every completed event it updates five running figures: the number of events, the sum of their latencies, the sum of their squared latencies, the smallest latency and the largest latency. A sample strobe freezes all five figures into a snapshot in a single cycle. Software can then read the snapshot without racing against the live counters.

The snapshot leaves through a single 32-bit read-only data port. Each read strobe steps to the next word in a fixed sequence, so one loop of reads collects the full statistics. The accumulator width is set at build time to 32 or 48 bits. A 48-bit value is split across two words, upper part first. A two-bit status output flags accumulator wrap-around and events that overlap. A clear strobe restarts the statistics.

Top module: `lat_stats`

## Requirements
- R1: A latency is the number of clock edges from the edge that samples a start pulse to the edge that samples the stop pulse. Each completed event adds one to the event count, which is readout word 0 (with CNT_W=32).
- R2: Each completed event adds its latency to the latency sum. With CNT_W=32 the sum is readout word 1.
- R3: Each completed event adds the exact square of its latency to the squared sum. The squared sum wraps modulo 2^CNT_W. With CNT_W=32 it is readout word 2.
- R4: The last readout word holds the minimum latency in bits 31:16 and the maximum latency in bits 15:0. Both are clamped to 0xFFFF when the latency exceeds 16 bits.
- R5: `rd_data` always shows the snapshot word at the current read position. Each cycle with `rd_en` high advances the position by one word.
- R6: With CNT_W=48 there are seven words, in this order: count upper, count lower, sum upper, sum lower, squares upper, squares lower, min/max. An upper word carries 0x0000 in bits 31:16 and value bits 47:32 in bits 15:0. A lower word carries value bits 31:0.
- R7: A write strobe, with any data, changes neither the snapshot, the read position nor the status.
- R8: `stat[1]` is set when any accumulator wraps past its maximum value. It stays set until clear.
- R9: `stat[0]` is set when a start pulse arrives while an event is in progress. The event in progress keeps its original start time. The bit stays set until clear.
- R10: A stop pulse that arrives while no event is in progress has no effect.
- R11: `sample` copies all live figures into the snapshot and returns the read position to word 0. Reads past the last word return zero.
- R12: `clear` zeroes the live count, sum, squared sum, maximum and both status bits, and sets the live minimum to 0xFFFF.
- R13: After reset the status is 0 and every snapshot word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Event start pulse |
| ev_stop | input | 1 | Event stop pulse |
| sample | input | 1 | Copy live figures to snapshot, rewind readout |
| clear | input | 1 | Restart live statistics and status |
| rd_en | input | 1 | Read strobe, advances readout |
| wr_en | input | 1 | Write strobe, ignored |
| wr_data | input | 32 | Write data, ignored |
| rd_data | output | 32 | Snapshot word at the current position |
| stat | output | 2 | Bit 1 wrap-around, bit 0 overlapping event |

## Verification
The bench builds two copies side by side with the same stimulus: one with CNT_W=32 and one with CNT_W=48, both with LAT_W=20. Sweeping latencies 1 to 12 through both copies checks the short and the split word layouts against the same arithmetic. A single event of 65536 cycles then serves three purposes. It wraps the 32-bit squared sum to exactly zero and raises the wrap flag. In the 48-bit copy it carries a one into the upper squares word without a flag. It also drives both the minimum and the maximum into the 16-bit clamp.

// File: rtl/lat_stats_pkg.sv
package lat_stats_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] lat16_t;

    typedef struct packed {
        lat16_t mn;
        lat16_t mx;
    } extrema_t;

    localparam lat16_t LAT16_MAX = '1;

    function automatic lat16_t clamp16(input logic [WORD_W-1:0] v);
        if (v > WORD_W'(LAT16_MAX)) begin
            return LAT16_MAX;
        end
        return v[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
    parameter int LAT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_stop,
    output logic             done,
    output logic             overlap,
    output logic [LAT_W-1:0] lat
);
    localparam logic [LAT_W-1:0] TMR_MAX = '1;

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] tmr;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        done    = st_q.busy & ev_stop;
        overlap = st_q.busy & ev_start;
        lat     = (st_q.tmr == TMR_MAX) ? TMR_MAX : st_q.tmr + 1'b1;
        if (!st_q.busy) begin
            // a stop with nothing in flight falls through untouched
            if (ev_start) begin
                st_d.busy = 1'b1;
                st_d.tmr  = '0;
            end
        end else if (ev_stop) begin
            st_d.busy = 1'b0;
            st_d.tmr  = '0;
        end else if (st_q.tmr != TMR_MAX) begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lat_accum.sv
module lat_accum
    import lat_stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LAT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             done,
    input  logic             overlap,
    input  logic [LAT_W-1:0] lat,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] sum,
    output logic [CNT_W-1:0] sq,
    output extrema_t         ext,
    output logic             ovf,
    output logic             full
);
    localparam int SQ_W  = 2 * LAT_W;
    localparam int EXT_W = ((CNT_W > SQ_W) ? CNT_W : SQ_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sum;
        logic [CNT_W-1:0] sq;
        extrema_t         ext;
        logic             ovf;
        logic             full;
    } acc_st_t;

    localparam acc_st_t ACC_INIT = '{
        cnt: '0, sum: '0, sq: '0,
        ext: '{mn: LAT16_MAX, mx: '0},
        ovf: 1'b0, full: 1'b0
    };

    acc_st_t          acc_d, acc_q;
    logic [SQ_W-1:0]  sq_full;
    logic [EXT_W-1:0] cnt_x, sum_x, sq_x;
    lat16_t           lat16;
    logic             wrap;

    always_comb begin
        acc_d   = acc_q;
        sq_full = SQ_W'(lat) * SQ_W'(lat);
        cnt_x   = EXT_W'(acc_q.cnt) + EXT_W'(1);
        sum_x   = EXT_W'(acc_q.sum) + EXT_W'(lat);
        sq_x    = EXT_W'(acc_q.sq) + EXT_W'(sq_full);
        lat16   = clamp16(WORD_W'(lat));
        wrap    = (|cnt_x[EXT_W-1:CNT_W]) | (|sum_x[EXT_W-1:CNT_W])
                | (|sq_x[EXT_W-1:CNT_W]);
        if (clear) begin
            acc_d = ACC_INIT;
        end else begin
            if (overlap) begin
                acc_d.full = 1'b1;
            end
            if (done) begin
                acc_d.cnt = cnt_x[CNT_W-1:0];
                acc_d.sum = sum_x[CNT_W-1:0];
                acc_d.sq  = sq_x[CNT_W-1:0];
                acc_d.ovf = acc_q.ovf | wrap;
                if (lat16 < acc_q.ext.mn) begin
                    acc_d.ext.mn = lat16;
                end
                if (lat16 > acc_q.ext.mx) begin
                    acc_d.ext.mx = lat16;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= ACC_INIT;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cnt  = acc_q.cnt;
    assign sum  = acc_q.sum;
    assign sq   = acc_q.sq;
    assign ext  = acc_q.ext;
    assign ovf  = acc_q.ovf;
    assign full = acc_q.full;

endmodule

// File: rtl/lat_readout.sv
module lat_readout
    import lat_stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  sum,
    input  logic [CNT_W-1:0]  sq,
    input  extrema_t          ext,
    output logic [WORD_W-1:0] rd_data
);
    localparam int WPV    = (CNT_W > WORD_W) ? 2 : 1;
    localparam int NWORDS = 3 * WPV + 1;
    localparam int PTR_W  = $clog2(NWORDS + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NWORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sum;
        logic [CNT_W-1:0] sq;
        extrema_t         ext;
        logic [PTR_W-1:0] ptr;
    } snap_st_t;

    snap_st_t          snap_d, snap_q;
    logic [WORD_W-1:0] words [NWORDS];

    always_comb begin
        snap_d = snap_q;
        if (sample) begin
            snap_d.cnt = cnt;
            snap_d.sum = sum;
            snap_d.sq  = sq;
            snap_d.ext = ext;
            snap_d.ptr = '0;
        end else if (rd_en && (snap_q.ptr != PTR_END)) begin
            snap_d.ptr = snap_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    generate
        if (WPV == 2) begin : g_split
            assign words[0] = WORD_W'(snap_q.cnt >> WORD_W);
            assign words[1] = snap_q.cnt[WORD_W-1:0];
            assign words[2] = WORD_W'(snap_q.sum >> WORD_W);
            assign words[3] = snap_q.sum[WORD_W-1:0];
            assign words[4] = WORD_W'(snap_q.sq >> WORD_W);
            assign words[5] = snap_q.sq[WORD_W-1:0];
            assign words[6] = snap_q.ext;
        end else begin : g_flat
            assign words[0] = snap_q.cnt[WORD_W-1:0];
            assign words[1] = snap_q.sum[WORD_W-1:0];
            assign words[2] = snap_q.sq[WORD_W-1:0];
            assign words[3] = snap_q.ext;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (snap_q.ptr == PTR_W'(i)) begin
                rd_data = words[i];
            end
        end
    end

endmodule

// File: rtl/lat_stats.sv
module lat_stats
    import lat_stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LAT_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        sample,
    input  logic        clear,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic [1:0]  stat
);
    logic             done, overlap, ovf, full;
    logic [LAT_W-1:0] lat;
    logic [CNT_W-1:0] cnt, sum, sq;
    extrema_t         ext;
    logic             wr_unused;

    // the data port accepts no writes
    assign wr_unused = wr_en ^ (^wr_data);

    lat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .done    (done),
        .overlap (overlap),
        .lat     (lat)
    );

    lat_accum #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .done   (done),
        .overlap(overlap),
        .lat    (lat),
        .cnt    (cnt),
        .sum    (sum),
        .sq     (sq),
        .ext    (ext),
        .ovf    (ovf),
        .full   (full)
    );

    lat_readout #(.CNT_W(CNT_W)) u_readout (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .rd_en  (rd_en),
        .cnt    (cnt),
        .sum    (sum),
        .sq     (sq),
        .ext    (ext),
        .rd_data(rd_data)
    );

    assign stat = {ovf, full};

endmodule

// File: rtl/lat_stats_chk.sv
module lat_stats_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        sample,
    input logic        clear,
    input logic        rd_en,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic [1:0]  stat
);
    // R9: overlap flag holds until clear
    p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] && !clear |=> stat[0]);

    // R9: overlap flag can only rise on a start pulse
    p_full_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[0] && !ev_start |=> !stat[0]);

    // R8: wrap flag holds until clear
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] && !clear |=> stat[1]);

    // R12: clear empties the status
    p_clear_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> stat == 2'b00);

    // R7: a write alone leaves the read port unchanged
    p_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_en && !sample |=> $stable(rd_data));

    // R5: without read or sample the shown word holds
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !sample |=> $stable(rd_data));

endmodule

bind lat_stats lat_stats_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_start(ev_start),
    .sample  (sample),
    .clear   (clear),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .stat    (stat)
);

// File: tb/test_lat_stats.sv
module test_lat_stats;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 1'b0, ev_stop = 1'b0, sample = 1'b0, clear = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_n, rd_w;
    logic [1:0]  stat_n, stat_w;

    always #5 clk = ~clk;

    lat_stats #(.CNT_W(32), .LAT_W(20)) i_lat_stats (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .sample(sample), .clear(clear), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_n), .stat(stat_n)
    );

    lat_stats #(.CNT_W(48), .LAT_W(20)) i_lat_stats_w48 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .sample(sample), .clear(clear), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_w), .stat(stat_w)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    longint unsigned m_cnt = 0, m_sum = 0, m_sq = 0;
    int unsigned     m_min = 32'hFFFF, m_max = 0;
    bit              m_full = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(bit wide, int idx);
        longint unsigned mask = wide ? ((64'd1 << 48) - 1) : ((64'd1 << 32) - 1);
        longint unsigned c = m_cnt & mask, s = m_sum & mask, q = m_sq & mask;
        logic [31:0] mm = {m_min[15:0], m_max[15:0]};
        if (wide) begin
            case (idx)
                0: return 32'(c >> 32);
                1: return c[31:0];
                2: return 32'(s >> 32);
                3: return s[31:0];
                4: return 32'(q >> 32);
                5: return q[31:0];
                6: return mm;
                default: return 32'h0;
            endcase
        end
        case (idx)
            0: return c[31:0];
            1: return s[31:0];
            2: return q[31:0];
            3: return mm;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] exp_stat(int w);
        longint unsigned lim = 64'd1 << w;
        return {(m_cnt >= lim) || (m_sum >= lim) || (m_sq >= lim), m_full};
    endfunction

    task automatic model_event(int lat);
        int unsigned s = (lat > 65535) ? 65535 : lat;
        m_cnt++;
        m_sum += longint'(lat);
        m_sq  += longint'(lat) * longint'(lat);
        if (s < m_min) m_min = s;
        if (s > m_max) m_max = s;
    endtask

    task automatic model_clear();
        m_cnt = 0; m_sum = 0; m_sq = 0;
        m_min = 32'hFFFF; m_max = 0; m_full = 0;
    endtask

    task automatic run_event(int lat);
        ev_start = 1'b1;
        @(negedge clk);
        ev_start = 1'b0;
        repeat (lat - 1) @(negedge clk);
        ev_stop = 1'b1;
        @(negedge clk);
        ev_stop = 1'b0;
        model_event(lat);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_sample();
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
    endtask

    // R1 R2 R3 R4 R5 R6 R11: walk every word and past the end
    task automatic read_all(string tag);
        for (int i = 0; i < 9; i++) begin
            check($sformatf("%s n32 word %0d", tag, i), rd_n, exp_word(0, i));
            check($sformatf("%s n48 word %0d", tag, i), rd_w, exp_word(1, i));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic check_stat(string tag);
        check({tag, " n32 stat R8 R9"}, {30'b0, stat_n}, {30'b0, exp_stat(32)});
        check({tag, " n48 stat R8 R9"}, {30'b0, stat_w}, {30'b0, exp_stat(48)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state, every snapshot word zero
        check("R13 n32 stat", {30'b0, stat_n}, 32'h0);
        check("R13 n48 stat", {30'b0, stat_w}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            check("R13 n32 word", rd_n, 32'h0);
            check("R13 n48 word", rd_w, 32'h0);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end

        // R10: stop with nothing in flight changes nothing
        ev_stop = 1'b1;
        @(negedge clk);
        ev_stop = 1'b0;
        repeat (2) @(negedge clk);
        pulse_sample();
        read_all("R10 stray stop");
        check_stat("R10");

        // R1 R2 R3 R4: latency sweep, sampled every fourth event
        for (int lat = 1; lat <= 12; lat++) begin
            run_event(lat);
            if (lat % 4 == 0) begin
                pulse_sample();
                read_all($sformatf("R1 R2 R3 R4 sweep to %0d", lat));
                check_stat("sweep");
            end
        end

        // R7: a write leaves word and position alone
        pulse_sample();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b1;
        wr_data = 32'hA5A5_5A5A;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        @(negedge clk);
        check("R7 n32 after write", rd_n, exp_word(0, 1));
        check("R7 n48 after write", rd_w, exp_word(1, 1));
        check_stat("R7");

        // R9: second start during an event; original start kept (latency 6)
        ev_start = 1'b1;
        @(negedge clk);
        ev_start = 1'b0;
        repeat (2) @(negedge clk);
        ev_start = 1'b1;
        @(negedge clk);
        ev_start = 1'b0;
        repeat (2) @(negedge clk);
        ev_stop = 1'b1;
        @(negedge clk);
        ev_stop = 1'b0;
        model_event(6);
        m_full = 1;
        @(negedge clk);
        check_stat("R9 overlap");
        pulse_sample();
        read_all("R9 overlap");

        // R12: clear restarts statistics; minimum back to 0xFFFF
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
        check_stat("R12 clear");
        pulse_sample();
        read_all("R12 cleared");

        // R8 R3 R4: one long event wraps the narrow squared sum, clamps extremes
        run_event(65536);
        pulse_sample();
        check_stat("R8 long event");
        read_all("R8 R3 R4 long event");

        // R11: a second sample rewinds to word 0
        pulse_sample();
        check("R11 n32 rewind", rd_n, exp_word(0, 0));
        check("R11 n48 rewind", rd_w, exp_word(1, 0));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule